// File: doc/BRIEF.md
# Gated Receive Byte Buffer

This block is a small circular byte store placed between a serial-to-byte deserializer and the register controller of a receiver. The deserializer offers bytes through a push strobe and is told how many free slots remain. The controller reads the oldest byte through a read strobe and tells the buffer whether reception is currently running.

Reception acts as a gate on the buffer. While it is stopped, the buffer reports no free space, refuses bytes and does not release any. Reading always presents the oldest slot, even when the buffer is empty, in which case the stale byte is returned and nothing moves. The buffer raises a one-cycle request to set the receive-ready event whenever a byte is accepted, and again after every pop that still leaves bytes waiting, so the controller sees a fresh event for each byte it can read.

Top module: `gated_rx_buffer`

## Requirements
- R1: After reset the head position and the byte count are zero: with reception stopped `free_slots_o` is 0, with reception running it equals DEPTH, and `ready_set_o` is low.
- R2: `free_slots_o` equals DEPTH minus the byte count in the same cycle while `rx_run_i` is high, and is 0 while `rx_run_i` is low.
- R3: A push is accepted only when `rx_run_i` is high and the count is below DEPTH; the byte is stored at slot (head + count) modulo DEPTH and the count rises by one at the next clock edge. A push made while stopped or while full changes nothing.
- R4: Every accepted push drives `ready_set_o` high for exactly one cycle, the cycle after the clock edge that accepts it.
- R5: `rd_byte_o` always shows the byte in the slot at the head position, combinationally, whether or not the buffer holds data.
- R6: A read strobe pops (head advances by one modulo DEPTH and the count falls by one) only when `rx_run_i` is high and the count is nonzero; a read while stopped or empty leaves the head, the count and `rd_byte_o` unchanged.
- R7: A pop that leaves the count nonzero drives `ready_set_o` high for the cycle after the popping edge; a pop that empties the buffer, with no push in the same cycle, leaves it low.
- R8: A push and a pop accepted in the same cycle both complete and the count is unchanged.
- R9: Bytes leave in the order they were accepted, including across the wrap of the head and write positions past slot DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_run_i | input | 1 | Reception running flag from the controller |
| push_i | input | 1 | Byte push strobe from the deserializer |
| push_byte_i | input | DATA_W | Byte offered with the push |
| free_slots_o | output | $clog2(DEPTH+1) | Free slots reported to the deserializer |
| rd_strobe_i | input | 1 | Read strobe from the controller |
| rd_byte_o | output | DATA_W | Byte at the head position |
| ready_set_o | output | 1 | One-cycle request to set the receive-ready event |

## Verification
`free_slots_o` and `rd_byte_o` are combinational and are due in the same cycle as the inputs that shape them, while the effects of a push or pop on the count and head appear only after the next rising edge. `ready_set_o` is registered, so its pulse is due one full cycle after the edge that accepted the push or pop. The bench drives every input on the falling edge, samples the combinational outputs one nanosecond later, and samples `ready_set_o` at the following falling edge, comparing all of them against an arithmetic model of head and count updated at the rising edge in between.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

   // Storage implementation choice for the byte slots.
   typedef enum logic [0:0] {
      RXB_ENTRY_FLOPS = 1'b0,   // one generated register per slot
      RXB_ARRAY_FLOPS = 1'b1    // one indexed array written in a single process
   } rxb_store_e;

endpackage

// File: rtl/rxb_store.sv
module rxb_store
   import rxb_pkg::*;
#(
   parameter int         DEPTH  = 6,
   parameter int         DATA_W = 8,
   parameter int         PW     = 3,
   parameter rxb_store_e KIND   = RXB_ENTRY_FLOPS
) (
   input  logic              clk,
   input  logic              wr_en_i,
   input  logic [PW-1:0]     wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [PW-1:0]     rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int FLAT_W = DEPTH * DATA_W;

   logic [FLAT_W-1:0] slots_flat;

   if (KIND == RXB_ENTRY_FLOPS) begin : g_entry
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [DATA_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == PW'(g))) begin
               slot_q <= wr_data_i;
            end
         end
         assign slots_flat[g*DATA_W +: DATA_W] = slot_q;
      end
   end else begin : g_array
      logic [DATA_W-1:0] mem_q [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
         end
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_flat
         assign slots_flat[g*DATA_W +: DATA_W] = mem_q[g];
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx_i == PW'(i)) begin
            rd_data_o = slots_flat[i*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/rxb_track.sv
module rxb_track #(
   parameter int DEPTH = 6,
   parameter int PW    = 3,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          push_i,
   input  logic          rd_i,
   output logic [PW-1:0] head_o,
   output logic [PW-1:0] wr_idx_o,
   output logic          wr_en_o,
   output logic [CW-1:0] free_o,
   output logic          ready_req_o
);

   localparam int SW = CW + 1;

   logic [PW-1:0] head_q, head_nx;
   logic [CW-1:0] count_q, count_nx;
   logic          push_ok, pop_ok;
   logic [SW-1:0] wr_sum;

   assign push_ok = push_i & run_i & (count_q != CW'(DEPTH));
   assign pop_ok  = rd_i & run_i & (count_q != '0);

   // Write slot: (head + count) modulo DEPTH; the sum never exceeds 2*DEPTH-1.
   assign wr_sum   = SW'(head_q) + SW'(count_q);
   assign wr_idx_o = (wr_sum >= SW'(DEPTH)) ? PW'(wr_sum - SW'(DEPTH)) : PW'(wr_sum);
   assign wr_en_o  = push_ok;

   always_comb begin
      head_nx = head_q;
      if (pop_ok) begin
         head_nx = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + PW'(1);
      end
   end

   always_comb begin
      unique case ({push_ok, pop_ok})
         2'b10:   count_nx = count_q + CW'(1);
         2'b01:   count_nx = count_q - CW'(1);
         default: count_nx = count_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= head_nx;
         count_q <= count_nx;
      end
   end

   assign head_o      = head_q;
   assign free_o      = run_i ? (CW'(DEPTH) - count_q) : '0;
   assign ready_req_o = push_ok | (pop_ok & (count_nx != '0));

   // R3: the count never passes the depth
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));

   // R3: a push into a full buffer without a pop leaves it full
   a_r3_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && run_i && count_q == CW'(DEPTH) && !rd_i) |=> (count_q == CW'(DEPTH)));

   // R2: no free space is reported while stopped
   a_r2_stopped_free: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> (free_o == '0));

   // R6: nothing moves while reception is stopped
   a_r6_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> ($stable(head_q) && $stable(count_q)));

   // R6: a lone pop lowers the count by one
   a_r6_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && run_i && count_q != '0 && !push_i) |=> (count_q == $past(count_q) - CW'(1)));

   // R8: simultaneous push and pop keep the count
   a_r8_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && pop_ok) |=> $stable(count_q));

endmodule

// File: rtl/rxb_event.sv
module rxb_event (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic pulse_o
);

   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= req_i;
      end
   end

   assign pulse_o = pulse_q;

   // R4: a request is presented as a pulse in the following cycle
   a_r4_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> pulse_o);

   // R7: no pulse appears without a request the cycle before
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !pulse_o);

endmodule

// File: rtl/gated_rx_buffer.sv
module gated_rx_buffer
   import rxb_pkg::*;
#(
   parameter int         DEPTH      = 6,
   parameter int         DATA_W     = 8,
   parameter rxb_store_e STORE_KIND = RXB_ENTRY_FLOPS,
   localparam int        PW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int        CW         = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_run_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_byte_i,
   output logic [CW-1:0]     free_slots_o,
   input  logic              rd_strobe_i,
   output logic [DATA_W-1:0] rd_byte_o,
   output logic              ready_set_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("gated_rx_buffer: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("gated_rx_buffer: DATA_W must be at least 1");
   end

   logic [PW-1:0] head;
   logic [PW-1:0] wr_idx;
   logic          wr_en;
   logic          ready_req;

   rxb_track #(
      .DEPTH (DEPTH),
      .PW    (PW),
      .CW    (CW)
   ) track_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (rx_run_i),
      .push_i      (push_i),
      .rd_i        (rd_strobe_i),
      .head_o      (head),
      .wr_idx_o    (wr_idx),
      .wr_en_o     (wr_en),
      .free_o      (free_slots_o),
      .ready_req_o (ready_req)
   );

   rxb_store #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .PW     (PW),
      .KIND   (STORE_KIND)
   ) store_i (
      .clk       (clk),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (push_byte_i),
      .rd_idx_i  (head),
      .rd_data_o (rd_byte_o)
   );

   rxb_event event_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (ready_req),
      .pulse_o (ready_set_o)
   );

   // R2: reported free space never exceeds the depth
   a_r2_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
      free_slots_o <= CW'(DEPTH));

   // R6: a stopped read keeps the presented byte
   a_r6_stopped_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_run_i && !$isunknown(rd_byte_o)) |=> $stable(rd_byte_o));

endmodule

// File: tb/gated_rx_buffer_tb_top.sv
`timescale 1ns/1ps
module gated_rx_buffer_tb_top;

   localparam int DEPTH = 6;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rx_run;
   logic          push;
   logic [7:0]    push_byte;
   logic [CW-1:0] free_slots;
   logic          rd_strobe;
   logic [7:0]    rd_byte;
   logic          ready_set;

   int n_tests = 0;
   int n_fail  = 0;

   // bench model
   logic [7:0] m_mem [DEPTH];
   bit         m_wr  [DEPTH];
   int         m_head = 0;
   int         m_cnt  = 0;

   gated_rx_buffer #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_run_i     (rx_run),
      .push_i       (push),
      .push_byte_i  (push_byte),
      .free_slots_o (free_slots),
      .rd_strobe_i  (rd_strobe),
      .rd_byte_o    (rd_byte),
      .ready_set_o  (ready_set)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, check combinational outputs,
   // cross the rising edge, check the registered event at the next falling edge.
   task automatic cyc(input bit run, input bit p, input bit rd,
                      input logic [7:0] b, input string tag);
      bit push_ok, pop_ok;
      int idx;
      bit exp_ready;
      rx_run = run; push = p; rd_strobe = rd; push_byte = b;
      #1;
      chk(int'(free_slots) == (run ? DEPTH - m_cnt : 0), tag, "free_slots",
          int'(free_slots), run ? DEPTH - m_cnt : 0);
      if (m_wr[m_head])
         chk(rd_byte == m_mem[m_head], tag, "rd_byte", int'(rd_byte), int'(m_mem[m_head]));
      push_ok = p && run && (m_cnt < DEPTH);
      pop_ok  = rd && run && (m_cnt > 0);
      idx = (m_head + m_cnt) % DEPTH;
      @(posedge clk);
      if (push_ok) begin
         m_mem[idx] = b;
         m_wr[idx]  = 1'b1;
      end
      if (pop_ok) m_head = (m_head + 1) % DEPTH;
      m_cnt = m_cnt + (push_ok ? 1 : 0) - (pop_ok ? 1 : 0);
      exp_ready = push_ok || (pop_ok && m_cnt > 0);
      @(negedge clk);
      chk(ready_set == exp_ready, tag, "ready_set", int'(ready_set), int'(exp_ready));
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      bit run_r;
      for (int i = 0; i < DEPTH; i++) m_wr[i] = 1'b0;
      rst_n = 1'b0; rx_run = 1'b0; push = 1'b0; rd_strobe = 1'b0; push_byte = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: reset state
      chk(free_slots == '0, "R1", "free_slots stopped", int'(free_slots), 0);
      chk(ready_set == 1'b0, "R1", "ready_set", int'(ready_set), 0);
      rx_run = 1'b1;
      #1;
      chk(int'(free_slots) == DEPTH, "R1", "free_slots running", int'(free_slots), DEPTH);
      @(negedge clk);

      // R3: pushes while stopped are discarded
      cyc(0, 1, 0, 8'hA5, "R3");
      cyc(1, 0, 0, 8'h00, "R3");
      chk(m_cnt == 0, "R3", "model count after stopped push", m_cnt, 0);

      // R3 / R4: fill, then overfill
      for (int i = 0; i < DEPTH; i++) cyc(1, 1, 0, 8'h10 + 8'(i), "R4");
      cyc(1, 1, 0, 8'hEE, "R3");
      cyc(1, 0, 0, 8'h00, "R3");
      chk(free_slots == '0, "R3", "free_slots when full", int'(free_slots), 0);

      // R2 / R6: stopped reads move nothing, free reports 0
      cyc(0, 0, 1, 8'h00, "R6");
      cyc(0, 0, 1, 8'h00, "R2");
      chk(rd_byte == 8'h10, "R6", "head byte after stopped read", int'(rd_byte), 8'h10);

      // R7: drain; last pop gives no event
      for (int i = 0; i < DEPTH; i++) cyc(1, 0, 1, 8'h00, "R7");

      // R5 / R6: empty reads return the stale head byte and move nothing
      cyc(1, 0, 1, 8'h00, "R6");
      cyc(1, 0, 1, 8'h00, "R5");
      chk(rd_byte == 8'h10, "R5", "stale head byte", int'(rd_byte), 8'h10);

      // R8: simultaneous push and pop
      cyc(1, 1, 0, 8'h31, "R8");
      cyc(1, 1, 1, 8'h32, "R8");
      cyc(1, 1, 1, 8'h33, "R8");
      cyc(1, 0, 0, 8'h00, "R8");
      chk(int'(free_slots) == DEPTH - 1, "R8", "free after paired ops", int'(free_slots), DEPTH - 1);
      cyc(1, 0, 1, 8'h00, "R8");

      // R9: wrap sweep at every fill level
      for (int lvl = 1; lvl <= DEPTH; lvl++) begin
         for (int k = 0; k < lvl; k++) cyc(1, 1, 0, 8'(lvl * 16 + k), "R9");
         for (int k = 0; k < 2 * DEPTH; k++) cyc(1, 1, 1, 8'(8'h80 + k), "R9");
         for (int k = 0; k < lvl; k++) cyc(1, 0, 1, 8'h00, "R9");
      end

      // R9: pseudo-random mix of run, push and read
      lfsr = 16'hACE1;
      run_r = 1'b1;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[7:4] == 4'h0) run_r = ~run_r;
         cyc(run_r, lfsr[0], lfsr[1] & lfsr[2], lfsr[15:8], "R9");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule